// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a fully associative cache of virtual-to-physical page translations that sits in front of a page table walker. Each lookup presents a virtual page number, an access kind (load, store or instruction fetch), the current privilege level and the current address-space tag. When a stored translation matches, the frame number comes back combinationally in the same cycle. When nothing matches, the block raises a walk request carrying the page number and tag. The walker answers later on a separate fill port, and the block installs that entry.

Every entry carries an address-space tag, so translations from several processes can live side by side without a flush on each context switch. A global flush and a per-tag flush are both provided. Each entry also holds read, write, execute and kernel-only permission bits, a present bit, and reference and dirty bits that the block maintains itself. Replacement is exact least-recently-used, kept as a per-entry age rank. Unused slots are always consumed before any live entry is evicted.

Top module: `tlb_tagged`

## Requirements
- R1: A lookup that matches a stored present entry with sufficient permission drives `lk_hit`=1 and `lk_pfn` to the stored frame in the same cycle, with `walk_req`=0.
- R2: A lookup that matches no stored entry drives `lk_hit`=0 and `walk_req`=1, with `walk_vpn` and `walk_asid` equal to the lookup page and tag. After a `fill_valid` cycle for that page and tag, the same lookup hits with the filled frame.
- R3: An entry matches only when both its page number and its tag equal the lookup's. The same page can be held under two tags at once, each returning its own frame.
- R4: While any slot is unoccupied, a fill of a new page and tag uses a free slot. After `ENTRIES` distinct fills into an empty buffer, all of them hit.
- R5: With every slot occupied, a fill of a new page replaces the entry whose last hit or fill lies furthest in the past.
- R6: `flush_all` invalidates every entry in one cycle, so any lookup in the following cycle misses.
- R7: `flush_tag` invalidates exactly the entries whose tag equals `flush_asid`. Entries with other tags keep hitting.
- R8: Access kind is encoded on `lk_acc` as 0 = load, 1 = store, 2 = fetch. `fill_perm` is encoded as bit0 = read, bit1 = write, bit2 = execute, bit3 = kernel-only. A matching present entry that lacks the needed read, write or execute bit drives `lk_fault`=1, `lk_hit`=0, `lk_pfn`=0 and `walk_req`=0.
- R9: A matching present entry with the kernel-only bit set faults (as in R8) when `lk_kmode`=0, and hits when `lk_kmode`=1 and the access bit allows it.
- R10: A matching entry filled with `fill_present`=0 drives `lk_trap`=1, `lk_hit`=0, `lk_fault`=0 and `walk_req`=0.
- R11: A fill installs the reference bit as 0. Each successful hit sets it, and faults do not. `lk_ref` shows the stored bit of the hit entry as it was before that hit.
- R12: A fill installs the dirty bit as 0. A store hit sets it, and load and fetch hits leave it unchanged. `lk_dirty` shows the stored bit of the hit entry as it was before that hit.
- R13: A fill whose page and tag already match a stored entry overwrites that entry in place instead of creating a second copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_kmode | input | 1 | 1 when the requester runs in kernel mode |
| cur_asid | input | ASID_W | Address-space tag of the current process |
| lk_hit | output | 1 | Translation returned |
| lk_pfn | output | PFN_W | Frame number on a hit, else 0 |
| lk_fault | output | 1 | Protection violation on a matching entry |
| lk_trap | output | 1 | Matching entry is marked not present |
| lk_ref | output | 1 | Reference bit of the hit entry before this hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this hit |
| walk_req | output | 1 | Miss: table walk needed |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_asid | output | ASID_W | Tag to walk under |
| fill_valid | input | 1 | Walker returns an entry this cycle |
| fill_vpn | input | VPN_W | Page number of the returned entry |
| fill_asid | input | ASID_W | Tag of the returned entry |
| fill_pfn | input | PFN_W | Frame number of the returned entry |
| fill_perm | input | 4 | bit0 read, bit1 write, bit2 execute, bit3 kernel-only |
| fill_present | input | 1 | 0 marks the translation not present |
| flush_all | input | 1 | Invalidate every entry |
| flush_tag | input | 1 | Invalidate entries whose tag equals flush_asid |
| flush_asid | input | ASID_W | Tag selected by flush_tag |

## Verification
On every cycle the assertions check the following: hit, fault, trap and walk request are mutually exclusive, at most one entry matches a lookup, and a fault never carries a frame. They also check that the age ranks keep exactly one oldest entry, that the touched entry becomes youngest, that a store hit leaves its entry dirty, and that both kinds of flush leave no surviving entry they should have removed. Which entry is chosen for eviction, whether free slots are used first, whether tags keep processes apart, and how reference and dirty bits appear on later hits depend on a history of fills and hits. Only the bench's directed scenarios can show these, by watching misses and hits after a planned sequence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    // bit3 kern, bit2 exec, bit1 wr, bit0 rd
    typedef struct packed {
        logic kern;
        logic exec;
        logic wr;
        logic rd;
    } perm_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             occ,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpns,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asids,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic [IDX_W-1:0]               hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = occ[g] && (vpns[g] == key_vpn) && (asids[g] == key_asid);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       kmode,
    input  perm_t      perm,
    output logic       deny
);

    logic need_ok;

    always_comb begin
        unique case (acc_e'(acc))
            ACC_LOAD:  need_ok = perm.rd;
            ACC_STORE: need_ok = perm.wr;
            ACC_FETCH: need_ok = perm.exec;
            default:   need_ok = 1'b0;
        endcase
        deny = !need_ok || (perm.kern && !kmode);
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] occ,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_state_t;

    lru_state_t st_d, st_q;
    logic [ENTRIES-1:0] oldest_vec;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;
    logic               any_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (st_q.age[g] == OLDEST);
    end

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < st_q.age[touch_idx]) begin
                    st_d.age[i] = st_q.age[i] + 1'b1;
                end
            end
        end

        any_free = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (oldest_vec[i]) old_idx = IDX_W'(i);
        end
        victim_idx = any_free ? free_idx : old_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assert_rank_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    assert_touch_youngest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> st_q.age[$past(touch_idx)] == '0);

endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_acc,
    input  logic              lk_kmode,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_fault,
    output logic              lk_trap,
    output logic              lk_ref,
    output logic              lk_dirty,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [3:0]        fill_perm,
    input  logic              fill_present,
    input  logic              flush_all,
    input  logic              flush_tag,
    input  logic [ASID_W-1:0] flush_asid
);

    typedef struct packed {
        logic  [ENTRIES-1:0]             occ;
        logic  [ENTRIES-1:0]             pres;
        logic  [ENTRIES-1:0]             refb;
        logic  [ENTRIES-1:0]             dirty;
        logic  [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic  [ENTRIES-1:0][ASID_W-1:0] asid;
        logic  [ENTRIES-1:0][PFN_W-1:0]  pfn;
        perm_t [ENTRIES-1:0]             perm;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_vec, fl_vec;
    logic [IDX_W-1:0]   lk_idx, fl_idx, victim_idx, fill_idx, touch_idx;
    logic               lk_any, fl_any, deny, touch_en;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_match_lk (
        .occ(st_q.occ), .vpns(st_q.vpn), .asids(st_q.asid),
        .key_vpn(lk_vpn), .key_asid(cur_asid),
        .hit_vec(lk_vec), .hit_idx(lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_match_fl (
        .occ(st_q.occ), .vpns(st_q.vpn), .asids(st_q.asid),
        .key_vpn(fill_vpn), .key_asid(fill_asid),
        .hit_vec(fl_vec), .hit_idx(fl_idx)
    );

    tlb_perm i_perm (
        .acc(lk_acc), .kmode(lk_kmode), .perm(st_q.perm[lk_idx]), .deny(deny)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .occ(st_q.occ), .victim_idx(victim_idx)
    );

    always_comb begin
        lk_any   = lk_valid && (|lk_vec);
        fl_any   = |fl_vec;
        lk_trap  = lk_any && !st_q.pres[lk_idx];
        lk_fault = lk_any && st_q.pres[lk_idx] && deny;
        lk_hit   = lk_any && st_q.pres[lk_idx] && !deny;
        lk_pfn   = lk_hit ? st_q.pfn[lk_idx] : '0;
        lk_ref   = lk_hit && st_q.refb[lk_idx];
        lk_dirty = lk_hit && st_q.dirty[lk_idx];
        walk_req  = lk_valid && !(|lk_vec);
        walk_vpn  = lk_vpn;
        walk_asid = cur_asid;

        fill_idx  = fl_any ? fl_idx : victim_idx;
        touch_en  = fill_valid || lk_hit;
        touch_idx = fill_valid ? fill_idx : lk_idx;

        st_d = st_q;
        if (lk_hit) begin
            st_d.refb[lk_idx] = 1'b1;
            if (acc_e'(lk_acc) == ACC_STORE) st_d.dirty[lk_idx] = 1'b1;
        end
        if (fill_valid) begin
            st_d.occ[fill_idx]   = 1'b1;
            st_d.pres[fill_idx]  = fill_present;
            st_d.refb[fill_idx]  = 1'b0;
            st_d.dirty[fill_idx] = 1'b0;
            st_d.vpn[fill_idx]   = fill_vpn;
            st_d.asid[fill_idx]  = fill_asid;
            st_d.pfn[fill_idx]   = fill_pfn;
            st_d.perm[fill_idx]  = perm_t'(fill_perm);
        end
        if (flush_tag) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_d.asid[i] == flush_asid) st_d.occ[i] = 1'b0;
            end
        end
        if (flush_all) st_d.occ = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_outcome_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_fault, lk_trap, walk_req}));

    assert_single_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    assert_fault_no_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_pfn == '0) && !lk_hit);

    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st_q.occ == '0));

    assert_store_dirty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && acc_e'(lk_acc) == ACC_STORE && !fill_valid && !flush_all && !flush_tag)
        |=> st_q.dirty[$past(lk_idx)]);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flush_chk
        assert_flush_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            flush_tag |=> !(st_q.occ[g] && st_q.asid[g] == $past(flush_asid)));
    end

endmodule

// File: tb/test_tlb_tagged.sv
module test_tlb_tagged;

    localparam int N      = 32;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_kmode = 1'b0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic              lk_hit, lk_fault, lk_trap, lk_ref, lk_dirty, walk_req;
    logic [PFN_W-1:0]  lk_pfn;
    logic [VPN_W-1:0]  walk_vpn;
    logic [ASID_W-1:0] walk_asid;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [3:0]        fill_perm = '0;
    logic              fill_present = 1'b0;
    logic              flush_all = 1'b0;
    logic              flush_tag = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic              o_hit, o_fault, o_trap, o_ref, o_dirty, o_walk;
    logic [PFN_W-1:0]  o_pfn;
    logic [VPN_W-1:0]  o_wvpn;
    logic [ASID_W-1:0] o_wasid;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
    localparam logic [3:0] P_RWX = 4'b0111, P_RO = 4'b0001, P_KRWX = 4'b1111;

    always #10 clk = ~clk;

    tlb_tagged #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) i_tlb_tagged (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc), .lk_kmode(lk_kmode),
        .cur_asid(cur_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault), .lk_trap(lk_trap),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_present(fill_present),
        .flush_all(flush_all), .flush_tag(flush_tag), .flush_asid(flush_asid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(logic [VPN_W-1:0] vpn, logic [1:0] acc, logic km, logic [ASID_W-1:0] asid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_acc = acc; lk_kmode = km; cur_asid = asid;
        #2;
        o_hit = lk_hit; o_pfn = lk_pfn; o_fault = lk_fault; o_trap = lk_trap;
        o_ref = lk_ref; o_dirty = lk_dirty; o_walk = walk_req;
        o_wvpn = walk_vpn; o_wasid = walk_asid;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic fill(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, logic [PFN_W-1:0] pfn,
                        logic [3:0] perm, logic pres);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_perm = perm; fill_present = pres;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid,
                              logic [PFN_W-1:0] pfn);
        lookup(vpn, LD, 1'b0, asid);
        check(req, {31'd0, o_hit}, 32'd1);
        check(req, 32'(o_pfn), 32'(pfn));
    endtask

    task automatic expect_miss(string req, logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
        lookup(vpn, LD, 1'b0, asid);
        check(req, {31'd0, o_hit}, 32'd0);
        check(req, {31'd0, o_walk}, 32'd1);
    endtask

    task automatic t_reset;
        lookup(20'h5, LD, 1'b0, 8'h0);
        check("R2 reset hit", {31'd0, o_hit}, 32'd0);
        check("R2 reset walk", {31'd0, o_walk}, 32'd1);
        check("R2 walk vpn", 32'(o_wvpn), 32'h5);
        check("R2 walk asid", 32'(o_wasid), 32'h0);
        check("R10 reset trap", {31'd0, o_trap}, 32'd0);
        check("R8 reset fault", {31'd0, o_fault}, 32'd0);
    endtask

    task automatic t_miss_fill;
        lookup(20'h10, LD, 1'b0, 8'h3);
        check("R2 miss walk", {31'd0, o_walk}, 32'd1);
        check("R2 walk asid", 32'(o_wasid), 32'h3);
        fill(20'h10, 8'h3, 20'hABC, P_RWX, 1'b1);
        lookup(20'h10, LD, 1'b0, 8'h3);
        check("R1 hit", {31'd0, o_hit}, 32'd1);
        check("R1 pfn", 32'(o_pfn), 32'hABC);
        check("R1 no walk", {31'd0, o_walk}, 32'd0);
        check("R11 ref after fill", {31'd0, o_ref}, 32'd0);
        lookup(20'h10, LD, 1'b0, 8'h3);
        check("R11 ref after hit", {31'd0, o_ref}, 32'd1);
        check("R12 load keeps clean", {31'd0, o_dirty}, 32'd0);
        lookup(20'h10, ST, 1'b0, 8'h3);
        check("R12 before store", {31'd0, o_dirty}, 32'd0);
        lookup(20'h10, FE, 1'b0, 8'h3);
        check("R12 dirty after store", {31'd0, o_dirty}, 32'd1);
    endtask

    task automatic t_tags;
        expect_miss("R3 other tag misses", 20'h10, 8'h4);
        fill(20'h10, 8'h4, 20'h111, P_RWX, 1'b1);
        expect_hit("R3 tag3 frame", 20'h10, 8'h3, 20'hABC);
        expect_hit("R3 tag4 frame", 20'h10, 8'h4, 20'h111);
    endtask

    task automatic t_perm;
        fill(20'h20, 8'h3, 20'h220, P_RO, 1'b1);
        lookup(20'h20, ST, 1'b0, 8'h3);
        check("R8 store fault", {31'd0, o_fault}, 32'd1);
        check("R8 store no hit", {31'd0, o_hit}, 32'd0);
        check("R8 store pfn", 32'(o_pfn), 32'd0);
        check("R8 store no walk", {31'd0, o_walk}, 32'd0);
        lookup(20'h20, FE, 1'b0, 8'h3);
        check("R8 fetch fault", {31'd0, o_fault}, 32'd1);
        lookup(20'h20, LD, 1'b0, 8'h3);
        check("R8 load ok", {31'd0, o_hit}, 32'd1);
        check("R11 fault leaves ref", {31'd0, o_ref}, 32'd0);
        fill(20'h21, 8'h3, 20'h221, P_KRWX, 1'b1);
        lookup(20'h21, LD, 1'b0, 8'h3);
        check("R9 user fault", {31'd0, o_fault}, 32'd1);
        check("R9 user no hit", {31'd0, o_hit}, 32'd0);
        lookup(20'h21, LD, 1'b1, 8'h3);
        check("R9 kernel hit", {31'd0, o_hit}, 32'd1);
        check("R9 kernel pfn", 32'(o_pfn), 32'h221);
    endtask

    task automatic t_trap;
        fill(20'h30, 8'h3, 20'h330, P_RWX, 1'b0);
        lookup(20'h30, LD, 1'b0, 8'h3);
        check("R10 trap", {31'd0, o_trap}, 32'd1);
        check("R10 no hit", {31'd0, o_hit}, 32'd0);
        check("R10 no walk", {31'd0, o_walk}, 32'd0);
        check("R10 no fault", {31'd0, o_fault}, 32'd0);
    endtask

    task automatic t_flush_tag;
        @(negedge clk);
        flush_tag = 1'b1; flush_asid = 8'h4;
        @(posedge clk); #1;
        flush_tag = 1'b0;
        expect_miss("R7 flushed tag", 20'h10, 8'h4);
        expect_hit("R7 other tag kept", 20'h10, 8'h3, 20'hABC);
    endtask

    task automatic t_flush_all;
        @(negedge clk);
        flush_all = 1'b1;
        @(posedge clk); #1;
        flush_all = 1'b0;
        expect_miss("R6 flush vpn10", 20'h10, 8'h3);
        expect_miss("R6 flush vpn20", 20'h20, 8'h3);
    endtask

    task automatic t_refill_capacity;
        fill(20'h300, 8'h7, 20'd1, P_RWX, 1'b1);
        fill(20'h300, 8'h7, 20'd2, P_RWX, 1'b1);
        for (int i = 1; i < N; i++) fill(20'h300 + 20'(i), 8'h7, 20'h300 + 20'(i), P_RWX, 1'b1);
        expect_hit("R13 overwritten frame", 20'h300, 8'h7, 20'd2);
        for (int i = 1; i < N; i++) expect_hit("R4 all slots hit", 20'h300 + 20'(i), 8'h7, 20'h300 + 20'(i));
    endtask

    task automatic t_lru;
        expect_hit("R5 touch oldest", 20'h300, 8'h7, 20'd2);
        fill(20'h400, 8'h7, 20'h400, P_RWX, 1'b1);
        expect_hit("R5 new entry", 20'h400, 8'h7, 20'h400);
        expect_hit("R5 touched kept", 20'h300, 8'h7, 20'd2);
        expect_hit("R5 next kept", 20'h302, 8'h7, 20'h302);
        expect_miss("R5 LRU evicted", 20'h301, 8'h7);
        fill(20'h401, 8'h7, 20'h401, P_RWX, 1'b1);
        expect_miss("R5 second eviction", 20'h303, 8'h7);
        expect_hit("R5 neighbour kept", 20'h304, 8'h7, 20'h304);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_fill();
        t_tags();
        t_perm();
        t_trap();
        t_flush_tag();
        t_flush_all();
        t_refill_capacity();
        t_lru();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule